// File: doc/BRIEF.md
# Word-Aligned Load/Store Byte Lane Unit

This unit sits between a 32-bit core and a data memory built from aligned 32-bit words with byte addressing. For each request it forms the effective address from a base register value and a signed 16-bit offset. It drives the memory with the word address, which always has its two low bits cleared. Word stores get byte write strobes. Word loads get their result selected straight from the returned data. A misaligned word access is flagged in the same cycle.

Two partial loads, "load-left" and "load-right", each take a run of bytes from the single aligned word that holds the effective address. They merge those bytes into the current destination register value and leave the remaining register bytes as they were. Run in sequence, the pair assembles an unaligned word, and neither one reads outside its own aligned word. A static mode input selects how byte numbers within a word map onto the data lanes, either big-endian or little-endian. The whole unit is combinational.

Top module: `lsu_lane_unit`

## Requirements
- R1: The effective address is `base_val` plus the sign-extended `offset`, modulo 2^32. `mem_addr` equals that address with bits [1:0] forced to zero.
- R2: When `req_valid` is high, `op` selects a word load (00) or a word store (01), and effective address bits [1:0] are nonzero, `align_exc` is 1 in that cycle. In that case `mem_be` is 0, `reg_we` is 0 and `reg_result` equals `old_reg`. All other requests give `align_exc` = 0.
- R3: An aligned valid word store drives `mem_be` = 4'b1111 and `mem_wdata` = `store_data`. Every load and every idle cycle (`req_valid` = 0) drives `mem_be` = 0.
- R4: An aligned valid word load gives `reg_result` = `mem_rdata` and `reg_we` = 1. An idle cycle gives `reg_we` = 0 and `align_exc` = 0.
- R5: Byte k (k = 0..3, the in-word offset) of the fetched word sits in data lane 3-k when `big_endian` = 1 and in lane k when it is 0. Lane j is bits [8j+7:8j], so byte 0 is the most significant byte in big-endian mode and the least significant in little-endian mode.
- R6: Load-left (`op` = 10) with in-word offset o sets register byte p to fetched byte p+o-3 for every p with p+o >= 3, and keeps `old_reg` byte p for all other p. For example, big-endian at address 6 fills the upper three register bytes with bytes 6, 5, 4 and keeps the lowest byte.
- R7: Load-right (`op` = 11) with in-word offset o sets register byte p to fetched byte p+o for every p with p+o <= 3, and keeps `old_reg` byte p for all other p. For example, big-endian at address 3 replaces only the lowest register byte with byte 3.
- R8: Valid load-left and load-right requests never raise `align_exc`, always assert `reg_we`, and assert no byte strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_valid | input | 1 | A request is present this cycle |
| op | input | 2 | 00 word load, 01 word store, 10 load-left, 11 load-right |
| big_endian | input | 1 | 1 selects big-endian lane order, 0 little-endian |
| base_val | input | 32 | Base register value |
| offset | input | 16 | Signed displacement |
| store_data | input | 32 | Register value to store |
| old_reg | input | 32 | Current value of the destination register |
| mem_rdata | input | 32 | Aligned word returned by memory |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Byte write strobes, lane j = bit j |
| mem_wdata | output | 32 | Store data toward memory |
| reg_result | output | 32 | Value to write into the destination register |
| reg_we | output | 1 | Destination register write enable |
| align_exc | output | 1 | Misaligned word access flag |

## Verification
The hardest cases to reach are the partial loads at every in-word offset, each in both byte orders. For these cases the effective address comes from an addition that may carry across the word boundary, so the offset the merge sees depends on base and displacement together. Random stimulus from a fixed seed mixes full 32-bit bases with negative and positive displacements, so that all four in-word offsets and carries into bit 2 occur under every operation and mode. Directed vectors pin the two documented big-endian examples and their little-endian mirrors to literal expected words. Further directed vectors aim misaligned word stores and loads at non-zero old register contents, so that any lane write or register update that leaks through shows at the ports.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;

  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int WORD_W = LANES * LANE_W;
  localparam int OFS_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    OP_LDW = 2'b00,
    OP_STW = 2'b01,
    OP_LDL = 2'b10,
    OP_LDR = 2'b11
  } mem_op_e;

  // Data lane that carries in-word byte k in the selected order.
  function automatic logic [OFS_W-1:0] lane_of(input logic [OFS_W-1:0] k,
                                               input logic be_mode);
    return be_mode ? ~k : k;
  endfunction

  function automatic logic [LANE_W-1:0] fetch_byte(input logic [WORD_W-1:0] word,
                                                   input logic [OFS_W-1:0] k,
                                                   input logic be_mode);
    logic [OFS_W-1:0] ln;
    ln = lane_of(k, be_mode);
    return word[LANE_W*ln +: LANE_W];
  endfunction

  function automatic logic is_word_op(input mem_op_e op);
    return (op == OP_LDW) || (op == OP_STW);
  endfunction

  // One register byte of a partial load: either a fetched byte or the old byte.
  function automatic logic [LANE_W-1:0] merge_byte(input mem_op_e op,
                                                   input logic [OFS_W-1:0] ofs,
                                                   input logic [OFS_W-1:0] pos,
                                                   input logic be_mode,
                                                   input logic [WORD_W-1:0] rdata,
                                                   input logic [LANE_W-1:0] old_b);
    logic [OFS_W:0]   sum;
    logic             take;
    logic [OFS_W-1:0] src;
    sum  = {1'b0, pos} + {1'b0, ofs};
    take = 1'b0;
    src  = '0;
    if (op == OP_LDL) begin
      take = (sum >= (OFS_W+1)'(LANES-1));
      src  = OFS_W'(sum - (OFS_W+1)'(LANES-1));
    end else if (op == OP_LDR) begin
      take = (sum <= (OFS_W+1)'(LANES-1));
      src  = OFS_W'(sum);
    end
    return take ? fetch_byte(rdata, src, be_mode) : old_b;
  endfunction

endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
  import lsu_lane_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic              req_valid,
  input  mem_op_e           op,
  input  logic [ADDR_W-1:0] base_val,
  input  logic [OFF_W-1:0]  offset,
  output logic [ADDR_W-1:0] word_addr,
  output logic [OFS_W-1:0]  byte_ofs,
  output logic              misalign
);

  localparam int EXT_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] eff_addr;

  assign eff_addr  = base_val + {{EXT_W{offset[OFF_W-1]}}, offset};
  assign byte_ofs  = eff_addr[OFS_W-1:0];
  assign word_addr = {eff_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
  assign misalign  = req_valid && is_word_op(op) && (byte_ofs != '0);

  always_comb begin
    AST_WORD_ADDR_ALIGNED: assert (word_addr[OFS_W-1:0] == '0) else $error("unaligned word address"); // R1
    if (misalign) begin
      AST_EXC_WORD_OPS_ONLY: assert (op == OP_LDW || op == OP_STW) else $error("exception on partial load"); // R2
    end
  end

endmodule

// File: rtl/lsu_lane_merge.sv
module lsu_lane_merge
  import lsu_lane_pkg::*;
(
  input  mem_op_e           op,
  input  logic [OFS_W-1:0]  byte_ofs,
  input  logic              big_endian,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic [WORD_W-1:0] old_reg,
  output logic [WORD_W-1:0] merged
);

  for (genvar P = 0; P < LANES; P++) begin : g_pos
    assign merged[LANE_W*P +: LANE_W] =
      merge_byte(op, byte_ofs, OFS_W'(P), big_endian, mem_rdata, old_reg[LANE_W*P +: LANE_W]);
  end

  always_comb begin
    if (op == OP_LDL && byte_ofs == '0) begin
      AST_LDL_SINGLE_TOP: assert (merged[WORD_W-LANE_W-1:0] == old_reg[WORD_W-LANE_W-1:0]) else $error("load-left touched low bytes"); // R6
    end
    if (op == OP_LDR && byte_ofs == OFS_W'(LANES-1)) begin
      AST_LDR_SINGLE_LOW: assert (merged[WORD_W-1:LANE_W] == old_reg[WORD_W-1:LANE_W]) else $error("load-right touched high bytes"); // R7
    end
  end

endmodule

// File: rtl/lsu_strobe.sv
module lsu_strobe
  import lsu_lane_pkg::*;
(
  input  logic             req_valid,
  input  mem_op_e          op,
  input  logic             misalign,
  output logic [LANES-1:0] byte_en,
  output logic             rf_we
);

  logic store_ok;

  assign store_ok = req_valid && (op == OP_STW) && !misalign;
  assign byte_en  = {LANES{store_ok}};
  assign rf_we    = req_valid && (op != OP_STW) && !misalign;

  always_comb begin
    if (req_valid && op != OP_STW) begin
      AST_LOAD_NO_STROBE: assert (byte_en == '0) else $error("strobe on load"); // R3
    end
  end

endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
  import lsu_lane_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic              req_valid,
  input  logic [1:0]        op,
  input  logic              big_endian,
  input  logic [ADDR_W-1:0] base_val,
  input  logic [OFF_W-1:0]  offset,
  input  logic [WORD_W-1:0] store_data,
  input  logic [WORD_W-1:0] old_reg,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_be,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [WORD_W-1:0] reg_result,
  output logic              reg_we,
  output logic              align_exc
);

  mem_op_e           op_e;
  logic [OFS_W-1:0]  byte_ofs;
  logic              misalign;
  logic [WORD_W-1:0] merged;

  assign op_e = mem_op_e'(op);

  lsu_agen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) i_agen (
    .req_valid (req_valid),
    .op        (op_e),
    .base_val  (base_val),
    .offset    (offset),
    .word_addr (mem_addr),
    .byte_ofs  (byte_ofs),
    .misalign  (misalign)
  );

  lsu_lane_merge i_merge (
    .op         (op_e),
    .byte_ofs   (byte_ofs),
    .big_endian (big_endian),
    .mem_rdata  (mem_rdata),
    .old_reg    (old_reg),
    .merged     (merged)
  );

  lsu_strobe i_strobe (
    .req_valid (req_valid),
    .op        (op_e),
    .misalign  (misalign),
    .byte_en   (mem_be),
    .rf_we     (reg_we)
  );

  assign align_exc = misalign;
  assign mem_wdata = store_data;

  always_comb begin
    if (misalign)                reg_result = old_reg;
    else if (op_e == OP_LDW)     reg_result = mem_rdata;
    else if (op_e == OP_STW)     reg_result = old_reg;
    else                         reg_result = merged;
  end

  always_comb begin
    if (align_exc) begin
      AST_EXC_BLOCKS_WRITES: assert (mem_be == '0 && !reg_we && reg_result == old_reg) else $error("write on exception"); // R2
    end
    if (req_valid && op_e == OP_STW && !align_exc) begin
      AST_STORE_ALL_LANES: assert (mem_be == {LANES{1'b1}}) else $error("partial store strobe"); // R3
    end
    if (req_valid && (op_e == OP_LDL || op_e == OP_LDR)) begin
      AST_PARTIAL_WRITES_REG: assert (reg_we && !align_exc) else $error("partial load not committed"); // R8
    end
  end

endmodule

// File: tb/test_lsu_lane_unit.sv
module test_lsu_lane_unit;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid, big_endian;
  logic [1:0]  op;
  logic [31:0] base_val, store_data, old_reg, mem_rdata;
  logic [15:0] offset;
  logic [31:0] mem_addr, mem_wdata, reg_result;
  logic [3:0]  mem_be;
  logic        reg_we, align_exc;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  lsu_lane_unit i_lsu_lane_unit (
    .req_valid(req_valid), .op(op), .big_endian(big_endian), .base_val(base_val),
    .offset(offset), .store_data(store_data), .old_reg(old_reg), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .reg_result(reg_result), .reg_we(reg_we), .align_exc(align_exc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h (op=%0d be=%0b base=%h off=%h)",
               req, act, exp, op, big_endian, base_val, offset);
    end
  endtask

  // Expected merge, written from R5..R7 on an explicit byte array.
  function automatic logic [31:0] exp_partial(input logic left, input logic [1:0] o,
                                              input logic bem, input logic [31:0] rd,
                                              input logic [31:0] old);
    logic [7:0] by [4];
    logic [31:0] r;
    for (int k = 0; k < 4; k++) by[k] = bem ? rd[8*(3-k) +: 8] : rd[8*k +: 8];
    r = old;
    for (int p = 0; p < 4; p++) begin
      if (left && (p + o >= 3))  r[8*p +: 8] = by[p + o - 3];
      if (!left && (p + o <= 3)) r[8*p +: 8] = by[p + o];
    end
    return r;
  endfunction

  task automatic drive(input logic v, input logic [1:0] o, input logic bem,
                       input logic [31:0] b, input logic [15:0] d,
                       input logic [31:0] sd, input logic [31:0] ol, input logic [31:0] rd);
    @(posedge clk);
    req_valid = v; op = o; big_endian = bem; base_val = b; offset = d;
    store_data = sd; old_reg = ol; mem_rdata = rd;
    @(negedge clk);
  endtask

  task automatic check_all();
    logic [31:0] ea;
    logic [1:0]  bo;
    logic        mis;
    ea  = base_val + {{16{offset[15]}}, offset};
    bo  = ea[1:0];
    mis = req_valid && (op <= 2'd1) && (bo != 2'd0);
    chk("R1 mem_addr", mem_addr, {ea[31:2], 2'b00});
    chk("R2 align_exc", {31'd0, align_exc}, {31'd0, mis});
    chk("R3 mem_wdata", mem_wdata, store_data);
    if (!req_valid) begin
      chk("R3 idle mem_be", {28'd0, mem_be}, 32'd0);
      chk("R4 idle reg_we", {31'd0, reg_we}, 32'd0);
    end else if (mis) begin
      chk("R2 exc mem_be", {28'd0, mem_be}, 32'd0);
      chk("R2 exc reg_we", {31'd0, reg_we}, 32'd0);
      chk("R2 exc reg_result", reg_result, old_reg);
    end else begin
      case (op)
        2'd0: begin
          chk("R4 ldw result", reg_result, mem_rdata);
          chk("R4 ldw reg_we", {31'd0, reg_we}, 32'd1);
          chk("R3 ldw mem_be", {28'd0, mem_be}, 32'd0);
        end
        2'd1: begin
          chk("R3 stw mem_be", {28'd0, mem_be}, 32'h0000000f);
          chk("R3 stw reg_we", {31'd0, reg_we}, 32'd0);
        end
        2'd2: begin
          chk("R6 ldl result", reg_result, exp_partial(1'b1, bo, big_endian, mem_rdata, old_reg));
          chk("R8 ldl reg_we", {31'd0, reg_we}, 32'd1);
          chk("R8 ldl mem_be", {28'd0, mem_be}, 32'd0);
        end
        default: begin
          chk("R7 ldr result", reg_result, exp_partial(1'b0, bo, big_endian, mem_rdata, old_reg));
          chk("R8 ldr reg_we", {31'd0, reg_we}, 32'd1);
          chk("R8 ldr mem_be", {28'd0, mem_be}, 32'd0);
        end
      endcase
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    req_valid = 0; op = 0; big_endian = 1; base_val = 0; offset = 0;
    store_data = 0; old_reg = 0; mem_rdata = 0;

    // idle state
    drive(1'b0, 2'd1, 1'b1, 32'h0000_0003, 16'h0, 32'h1, 32'hAABBCCDD, 32'h0);
    chk("R3 reset mem_be", {28'd0, mem_be}, 32'd0);
    chk("R4 reset reg_we", {31'd0, reg_we}, 32'd0);
    chk("R2 reset align_exc", {31'd0, align_exc}, 32'd0);

    // R6 big-endian load-left at address 6: bytes 6,5,4 into upper three lanes
    drive(1'b1, 2'd2, 1'b1, 32'h0000_0000, 16'h0006, 32'h0, 32'hAABBCCDD, 32'h11223344);
    chk("R6 be ldl @6", reg_result, 32'h332211DD);
    // R7 big-endian load-right at address 3: only lowest lane
    drive(1'b1, 2'd3, 1'b1, 32'h0000_0000, 16'h0003, 32'h0, 32'hAABBCCDD, 32'h11223344);
    chk("R7 be ldr @3", reg_result, 32'hAABBCC44);
    // R5 little-endian mirrors the lane of each byte
    drive(1'b1, 2'd2, 1'b0, 32'h0000_0000, 16'h0006, 32'h0, 32'hAABBCCDD, 32'h11223344);
    chk("R5 le ldl @6", reg_result, 32'h223344DD);
    drive(1'b1, 2'd3, 1'b0, 32'h0000_0000, 16'h0003, 32'h0, 32'hAABBCCDD, 32'h11223344);
    chk("R5 le ldr @3", reg_result, 32'hAABBCC11);
    // R1 negative offset with borrow across the word
    drive(1'b1, 2'd0, 1'b1, 32'h0000_1000, 16'hFFFC, 32'h0, 32'h0, 32'hCAFEF00D);
    chk("R1 neg offset addr", mem_addr, 32'h0000_0FFC);
    chk("R4 ldw aligned", reg_result, 32'hCAFEF00D);
    // R2 misaligned store and load
    drive(1'b1, 2'd1, 1'b0, 32'h0000_2001, 16'h0000, 32'h12345678, 32'h55AA55AA, 32'h0);
    chk("R2 stw misaligned exc", {31'd0, align_exc}, 32'd1);
    chk("R2 stw misaligned be", {28'd0, mem_be}, 32'd0);
    drive(1'b1, 2'd0, 1'b1, 32'h0000_2000, 16'h0002, 32'h0, 32'h55AA55AA, 32'hFFFFFFFF);
    chk("R2 ldw misaligned keep", reg_result, 32'h55AA55AA);
    chk("R2 ldw misaligned we", {31'd0, reg_we}, 32'd0);
    // R8 partial loads at odd addresses never trap
    drive(1'b1, 2'd3, 1'b1, 32'h0000_2001, 16'h0000, 32'h0, 32'h0, 32'h0);
    chk("R8 ldr odd no exc", {31'd0, align_exc}, 32'd0);

    for (int n = 0; n < 3000; n++) begin
      logic [15:0] d;
      d = ($urandom % 4 == 0) ? 16'($urandom) : 16'(($urandom % 64) - 32);
      drive(($urandom % 8) != 0, 2'($urandom), 1'($urandom), $urandom, d,
            $urandom, $urandom, $urandom);
      check_all();
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule